// File: doc/BRIEF.md
# Load-Use Interlock Stall Controller

This block is the hazard-detection logic that sits beside the decode stage of a five-stage in-order pipeline. It tracks whether the instruction now in the execute stage is a load and which register that load will write. Load data exists only once the memory stage has finished. A decode-stage instruction that needs that register as an execute-stage operand in the next cycle therefore cannot be served by the bypass network. The controller detects this case and raises three hold signals for exactly one cycle. These freeze the program counter and the fetch/decode register and turn the decode/execute register into a no-op. Older instructions continue down the pipeline, and the normal bypass path delivers the loaded value once the dependent instruction reaches execute.

The decoder reports, for each source field, whether the instruction reads that register in the execute stage. A store's data operand is consumed only in the memory stage and is bypassed there, so the decoder marks it as not needed in execute and it never causes a stall. The same applies to a field that an immediate-form operation does not read. The controller keeps its own copy of the execute-stage load flag and destination. It loads this copy from the decode stage at every clock edge and clears it when a bubble is injected.

Top module: `lduse_interlock`

## Requirements
- R1: After reset the tracked execute-stage slot holds no load, and pc_hold, ifid_hold and idex_bubble are 0 until a load has been accepted from decode.
- R2: When the execute-stage slot holds a load with destination d (d not 0), and any decode source i has id_src_used[i]=1 and id_src_idx[i]=d, all three hold outputs are 1 in that same cycle.
- R3: pc_hold, ifid_hold and idex_bubble are equal in every cycle.
- R4: A load whose destination is register 0 never causes a stall.
- R5: A source whose id_src_used bit is 0 never causes a stall, even if its index matches the load destination. This covers store data and unused immediate-form fields.
- R6: An execute-stage instruction that is not a load (id_is_load was 0 when it left decode) never causes a stall.
- R7: A stall lasts exactly one cycle. In the cycle after a stall the held decode instruction sees an empty execute slot and is not stalled.
- R8: During a stall, the decode instruction does not enter the execute slot. It enters when it leaves decode in the following cycle: a stalled load is tracked only after its held cycle, and it then stalls its own dependent.
- R9: An instruction two or more slots behind a load never stalls on that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_idx | input | NUM_SRC x log2(NUM_REGS) | Register index of each decode-stage source field |
| id_src_used | input | NUM_SRC | Bit i set when source i is read in the execute stage |
| id_is_load | input | 1 | Decode-stage instruction is a load |
| id_dst | input | log2(NUM_REGS) | Destination register of the decode-stage instruction |
| pc_hold | output | 1 | Freeze the program counter this cycle |
| ifid_hold | output | 1 | Freeze the fetch/decode register this cycle |
| idex_bubble | output | 1 | Write a no-op into the decode/execute register this cycle |

## Verification
The hardest case to reach from the ports is a stalled instruction that is itself a load. Its execute-slot entry has to be suppressed during the held cycle and then take effect one cycle later. The bench reaches this case by offering a stalled load, holding it through its bubble, and then presenting a reader of its destination, which must then stall. The bench also covers every combination of load flag, destination, two source indices and two use bits in a small 8-register configuration. For each combination it checks the stall cycle and the cycle after it. It also checks a reader placed two slots behind each load.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Hold controls issued to the front of the pipeline.
    typedef struct packed {
        logic pc;
        logic ifid;
        logic idex;
    } hold_ctrl_t;

    function automatic hold_ctrl_t mk_hold(input logic stall);
        hold_ctrl_t h;
        h.pc   = stall;
        h.ifid = stall;
        h.idex = stall;
        return h;
    endfunction

endpackage

// File: rtl/hzd_ex_tag.sv
module hzd_ex_tag #(
    parameter int unsigned RAW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bubble,
    input  logic           dec_is_load,
    input  logic [RAW-1:0] dec_dst,
    output logic           armed,
    output logic [RAW-1:0] ex_dst
);
    logic           ld_q;
    logic [RAW-1:0] dst_q;

    always_ff @(posedge clk) begin
        if (rst || bubble) begin
            ld_q  <= 1'b0;
            dst_q <= '0;
        end else begin
            ld_q  <= dec_is_load;
            dst_q <= dec_dst;
        end
    end

    // Register 0 is never a real producer.
    assign armed  = ld_q && (dst_q != '0);
    assign ex_dst = dst_q;
endmodule

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int unsigned RAW = 5
) (
    input  logic           used,
    input  logic [RAW-1:0] idx,
    input  logic           armed,
    input  logic [RAW-1:0] ex_dst,
    output logic           hit
);
    assign hit = armed && used && (idx == ex_dst);
endmodule

// File: rtl/lduse_interlock.sv
module lduse_interlock
    import hzd_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned NUM_SRC  = 2,
    localparam int unsigned RAW     = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0][RAW-1:0]   id_src_idx,
    input  logic [NUM_SRC-1:0]            id_src_used,
    input  logic                          id_is_load,
    input  logic [RAW-1:0]                id_dst,
    output logic                          pc_hold,
    output logic                          ifid_hold,
    output logic                          idex_bubble
);
    logic           armed;
    logic [RAW-1:0] ex_dst;
    logic [NUM_SRC-1:0] hits;
    logic           stall;
    hold_ctrl_t     hold;

    hzd_ex_tag #(.RAW(RAW)) u_tag (
        .clk        (clk),
        .rst        (rst),
        .bubble     (stall),
        .dec_is_load(id_is_load),
        .dec_dst    (id_dst),
        .armed      (armed),
        .ex_dst     (ex_dst)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hzd_src_cmp #(.RAW(RAW)) u_cmp (
            .used  (id_src_used[g]),
            .idx   (id_src_idx[g]),
            .armed (armed),
            .ex_dst(ex_dst),
            .hit   (hits[g])
        );
    end

    assign stall = |hits;

    always_comb hold = mk_hold(stall);

    assign pc_hold     = hold.pc;
    assign ifid_hold   = hold.ifid;
    assign idex_bubble = hold.idex;
endmodule

// File: rtl/lduse_interlock_chk.sv
module lduse_interlock_chk #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned NUM_SRC  = 2,
    localparam int unsigned RAW     = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0][RAW-1:0]   id_src_idx,
    input  logic [NUM_SRC-1:0]            id_src_used,
    input  logic                          id_is_load,
    input  logic [RAW-1:0]                id_dst,
    input  logic                          pc_hold,
    input  logic                          ifid_hold,
    input  logic                          idex_bubble
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_outs_equal_r3: assert property (@(posedge clk) disable iff (rst)
        (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !past_ok |-> !pc_hold);

    p_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> !pc_hold);

    p_zero_dst_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !pc_hold && id_is_load && id_dst == '0) |=> !pc_hold);

    p_nonload_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !id_is_load) |=> !pc_hold);

    p_unused_src_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !pc_hold) |=> (id_src_used != '0 || !pc_hold));

    p_src0_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !pc_hold && id_is_load && id_dst != '0) |=>
        (!(id_src_used[0] && id_src_idx[0] == $past(id_dst)) || pc_hold));
endmodule

bind lduse_interlock lduse_interlock_chk #(
    .NUM_REGS(NUM_REGS),
    .NUM_SRC (NUM_SRC)
) u_chk (.*);

// File: tb/test_lduse_interlock.sv
module test_lduse_interlock;
    localparam int unsigned NR  = 8;
    localparam int unsigned RAW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0][RAW-1:0] src_idx = '0;
    logic [1:0]          src_used = '0;
    logic                is_load = 1'b0;
    logic [RAW-1:0]      dst = '0;
    logic pc_hold, ifid_hold, idex_bubble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lduse_interlock #(.NUM_REGS(NR), .NUM_SRC(2)) i_lduse_interlock (
        .clk(clk), .rst(rst),
        .id_src_idx(src_idx), .id_src_used(src_used),
        .id_is_load(is_load), .id_dst(dst),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic expect_stall(input logic exp, input string req);
        checks++;
        if (pc_hold !== exp || ifid_hold !== exp || idex_bubble !== exp) begin
            errors++;
            $display("FAIL %s: holds pc=%b ifid=%b idex=%b expected %b",
                     req, pc_hold, ifid_hold, idex_bubble, exp);
        end
    endtask

    // Drive one decode-stage instruction after the falling edge.
    task automatic drive(input logic ld, input logic [RAW-1:0] d,
                         input logic [RAW-1:0] s0, input logic [RAW-1:0] s1,
                         input logic [1:0] u);
        @(negedge clk);
        is_load = ld; dst = d;
        src_idx[0] = s0; src_idx[1] = s1; src_used = u;
        #1;
    endtask

    task automatic neutral();
        drive(1'b0, '0, '0, '0, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        expect_stall(1'b0, "R1 reset");
        // Source matching register 0 right after reset: slot is empty.
        drive(1'b0, '0, 3'd0, 3'd0, 2'b11);
        expect_stall(1'b0, "R1 after reset");

        // Exhaustive producer/consumer sweep.
        for (int ld = 0; ld < 2; ld++)
        for (int d = 0; d < NR; d++)
        for (int s0 = 0; s0 < NR; s0++)
        for (int s1 = 0; s1 < NR; s1++)
        for (int u = 0; u < 4; u++) begin
            logic exp;
            neutral();
            drive(ld[0], d[RAW-1:0], s0[RAW-1:0], s1[RAW-1:0], 2'b00);
            expect_stall(1'b0, "R5 producer unused srcs");
            exp = (ld == 1) && (d != 0) &&
                  ((u[0] && s0 == d) || (u[1] && s1 == d));
            drive(1'b0, '0, s0[RAW-1:0], s1[RAW-1:0], u[1:0]);
            if (ld == 0)             expect_stall(1'b0, "R6 non-load");
            else if (d == 0)         expect_stall(1'b0, "R4 dst zero");
            else if (!exp)           expect_stall(1'b0, "R5 unused or no match");
            else                     expect_stall(1'b1, "R2 load-use");
            if (exp) begin
                drive(1'b0, '0, s0[RAW-1:0], s1[RAW-1:0], u[1:0]);
                expect_stall(1'b0, "R7 one cycle");
            end
        end

        // Two slots behind: no stall.
        for (int d = 1; d < NR; d++) begin
            neutral();
            drive(1'b1, d[RAW-1:0], '0, '0, 2'b00);
            drive(1'b0, '0, '0, '0, 2'b00);
            drive(1'b0, '0, d[RAW-1:0], d[RAW-1:0], 2'b11);
            expect_stall(1'b0, "R9 two behind");
        end

        // Stalled load enters the execute slot only after its held cycle.
        for (int d = 1; d < NR; d++) begin
            logic [RAW-1:0] d2;
            d2 = RAW'((d % (NR - 1)) + 1);
            neutral();
            drive(1'b1, d[RAW-1:0], '0, '0, 2'b00);
            drive(1'b1, d2, d[RAW-1:0], '0, 2'b01);
            expect_stall(1'b1, "R8 stalled load");
            drive(1'b1, d2, d[RAW-1:0], '0, 2'b01);
            expect_stall(1'b0, "R8 held cycle");
            drive(1'b0, '0, '0, d2, 2'b10);
            expect_stall(1'b1, "R8 stalled load tracked late");
        end

        // Reset mid-stream clears the slot.
        drive(1'b1, 3'd5, '0, '0, 2'b00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        src_idx[0] = 3'd5; src_used = 2'b01; is_load = 1'b0; #1;
        expect_stall(1'b0, "R1 reset clears");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule